// File: doc/BRIEF.md
# Fine-Grained Configurable Logic Cell

This block is one tile of a fine-grained programmable logic array. The tile has one input and one output on each of its four sides: north, east, south and west. Three selectors each pick one neighbour input. One selected value is the select line of a 2:1 multiplexer, and the other two are its data inputs. Each data input can be complemented on the way in. With these choices the multiplexer can compute most functions of two variables, for example AND and XOR.

The multiplexer result can be used directly, or it can be taken from a D flip-flop that captures it on every clock. Each side output is chosen from two kinds of source. One is the cell's own result. The others are the inputs of the other three sides, which lets a signal pass through the cell on its way to a cell further away.

All choices come from a 17-bit configuration word. The word is shifted in serially, and the bit shifted out of the top of the register appears on a chain output. This lets several tiles share one configuration path.

Top module: `logic_tile`

## Requirements
- R1: While `cfg_en` is 1, every rising clock shifts `cfg_in` into the bottom of the 17-bit configuration register, so the word is loaded most significant bit first. `cfg_out` always shows the top bit. A word loaded earlier therefore leaves on `cfg_out`, MSB first, during the next 17 shift cycles.
- R2: While `cfg_en` is 0, the configuration does not change, and neither `cfg_in` nor `cfg_out` has any effect on the routing or the logic.
- R3: When `cfg_rst_n` is 0 at a rising clock, every configuration bit becomes 0. The tile then drives the combinational result on all four outputs, and that result equals `n_in`.
- R4: Configuration layout, from bit 16 down to bit 0:
  - route codes for N [16:15], E [14:13], S [12:11] and W [10:9];
  - invert bit for the first data input [8] and for the second data input [7];
  - selector for the select line [6:5], the first data input [4:3] and the second data input [2:1];
  - register-mode bit [0].
  
  The selector codes are 00 = north, 01 = east, 10 = south and 11 = west. The result is the second data input when the select line is 1, and the first data input when it is 0.
- R5: An invert bit of 1 complements the selected value before it enters the multiplexer. This makes XOR possible.
- R6: A route code of 00 drives the cell result on that side. Codes 01, 10 and 11 drive the input of the next, the second and the third side clockwise from the output's own side. For example, for north they select east, south and west.
- R7: When the register-mode bit is 1, the cell result is the flip-flop output. That output equals the combinational result of the previous clock cycle, which is exactly one cycle of latency.
- R8: When `ff_rst_n` is 0 at a rising clock, the flip-flop becomes 0. This reset leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cfg_rst_n | input | 1 | Synchronous active-low clear of the configuration |
| ff_rst_n | input | 1 | Synchronous active-low clear of the user flip-flop |
| cfg_en | input | 1 | Shift enable for configuration loading |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out, for chaining |
| n_in | input | 1 | Input from the north neighbour |
| e_in | input | 1 | Input from the east neighbour |
| s_in | input | 1 | Input from the south neighbour |
| w_in | input | 1 | Input from the west neighbour |
| n_out | output | 1 | Output to the north neighbour |
| e_out | output | 1 | Output to the east neighbour |
| s_out | output | 1 | Output to the south neighbour |
| w_out | output | 1 | Output to the west neighbour |

## Verification
A configuration register with a wrong bit shows up at the side outputs at once, in the same cycle, under any input pattern that the wrong bit makes matter. It also shows up on `cfg_out` when that bit is later shifted out, at most 17 cycles later. A flip-flop with a wrong value shows up in register mode on the next sampled cycle. It is replaced by the correct value one clock later, so the latency checks sample both the cycle before and the cycle after each input change. The reference model is compared against all five outputs on every clock, so the cycle in which a fault first appears is reported.

// File: rtl/tile_pkg.sv
`timescale 1ns/1ps
// tile_pkg: shared sizes, field layout and types for the logic tile.
// Assumes four sides, with side index 0..3 = north, east, south, west.
package tile_pkg;
    localparam int N_SIDES    = 4;
    localparam int SIDE_SEL_W = $clog2(N_SIDES);
    localparam int N_PICKS    = 3;
    localparam int N_INVERTS  = 2;
    localparam int CFG_W      = N_SIDES * SIDE_SEL_W + N_INVERTS
                              + N_PICKS * SIDE_SEL_W + 1;

    typedef logic [SIDE_SEL_W-1:0] side_code_t;

    // Packed MSB first, in the same order as the serial stream.
    typedef struct packed {
        side_code_t route_n;
        side_code_t route_e;
        side_code_t route_s;
        side_code_t route_w;
        logic       flip_a;
        logic       flip_b;
        side_code_t pick_sel;
        side_code_t pick_a;
        side_code_t pick_b;
        logic       reg_mode;
    } tile_cfg_t;
endpackage

// File: rtl/tile_cfg_chain.sv
`timescale 1ns/1ps
// tile_cfg_chain: serial configuration register. Data enters at bit 0 and
// leaves at bit W-1, so a word is loaded MSB first.
// Assumes W >= 2. Reset is synchronous, active low, and takes priority.
module tile_cfg_chain #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         dout
);
    // Shift one bit per enabled clock; hold otherwise.
    always_ff @(posedge clk) begin : shift_reg
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= {q[W-2:0], din};
    end

    // The top bit feeds the next tile in the chain.
    assign dout = q[W-1];
endmodule

// File: rtl/tile_pick.sv
`timescale 1ns/1ps
// tile_pick: N:1 neighbour selector with an optional inversion.
// Assumes that code indexes side inputs in the order north, east, south, west.
module tile_pick #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic [N-1:0]  side_in,
    input  logic [SW-1:0] code,
    input  logic          flip,
    output logic          y
);
    // Choose one side and optionally complement it.
    always_comb begin : pick_mux
        y = side_in[code] ^ flip;
    end
endmodule

// File: rtl/tile_ulm.sv
`timescale 1ns/1ps
// tile_ulm: 2:1 multiplexer used as a universal two-input function, followed
// by a user flip-flop and a combinational/registered result select.
// Assumes that the flip-flop reset is synchronous and active low.
module tile_ulm (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic a,
    input  logic b,
    input  logic reg_mode,
    output logic f_comb,
    output logic ff_q,
    output logic res
);
    // Universal logic function: the select line picks b when 1, a when 0.
    always_comb begin : ulm_mux
        f_comb = sel ? b : a;
    end

    // User register: captures the function output on every clock.
    always_ff @(posedge clk) begin : user_ff
        if (!rst_n)
            ff_q <= 1'b0;
        else
            ff_q <= f_comb;
    end

    // Result select: registered or combinational.
    always_comb begin : result_sel
        res = reg_mode ? ff_q : f_comb;
    end
endmodule

// File: rtl/tile_route.sv
`timescale 1ns/1ps
// tile_route: output multiplexer for one side. Code 0 drives the cell result.
// Code k drives the input of the side k steps clockwise from SIDE.
// Assumes N == 2**SW, so the clockwise index wraps by truncation.
module tile_route #(
    parameter int N    = 4,
    parameter int SW   = 2,
    parameter int SIDE = 0
) (
    input  logic          res,
    input  logic [N-1:0]  side_in,
    input  logic [SW-1:0] code,
    output logic          y
);
    localparam logic [SW:0] SIDE_IDX = SIDE[SW:0];

    logic [SW:0]   sum;
    logic [SW-1:0] idx;

    // Wrap the clockwise offset into a side index.
    always_comb begin : wrap_index
        sum = {1'b0, code} + SIDE_IDX;
        idx = sum[SW-1:0];
    end

    // Drive either the own result or a pass-through neighbour.
    always_comb begin : route_mux
        y = (code == '0) ? res : side_in[idx];
    end
endmodule

// File: rtl/logic_tile.sv
`timescale 1ns/1ps
// logic_tile: one fine-grained configurable cell with four-side local
// routing and a serially loaded 17-bit configuration word.
// Assumes that both resets are synchronous and active low. The configuration
// reset does not touch the user flip-flop, and the other reset does not
// touch the configuration.
module logic_tile
    import tile_pkg::*;
(
    input  logic clk,
    input  logic cfg_rst_n,
    input  logic ff_rst_n,
    input  logic cfg_en,
    input  logic cfg_in,
    output logic cfg_out,
    input  logic n_in,
    input  logic e_in,
    input  logic s_in,
    input  logic w_in,
    output logic n_out,
    output logic e_out,
    output logic s_out,
    output logic w_out
);
    logic [CFG_W-1:0]   cfg_bits;
    tile_cfg_t          cfg_q;
    logic [N_SIDES-1:0] side_in;
    logic [N_SIDES-1:0] side_out;
    side_code_t         route_code [N_SIDES];
    side_code_t         pick_code  [N_PICKS];
    logic               pick_flip  [N_PICKS];
    logic               pick_val   [N_PICKS];
    logic               f_comb;
    logic               ff_q;
    logic               res;

    tile_cfg_chain #(.W(CFG_W)) u_chain (
        .clk   (clk),
        .rst_n (cfg_rst_n),
        .en    (cfg_en),
        .din   (cfg_in),
        .q     (cfg_bits),
        .dout  (cfg_out)
    );

    // Unpack the configuration fields and gather the side inputs.
    always_comb begin : field_map
        cfg_q         = tile_cfg_t'(cfg_bits);
        side_in       = {w_in, s_in, e_in, n_in};
        route_code[0] = cfg_q.route_n;
        route_code[1] = cfg_q.route_e;
        route_code[2] = cfg_q.route_s;
        route_code[3] = cfg_q.route_w;
        pick_code[0]  = cfg_q.pick_sel;
        pick_code[1]  = cfg_q.pick_a;
        pick_code[2]  = cfg_q.pick_b;
        pick_flip[0]  = 1'b0;
        pick_flip[1]  = cfg_q.flip_a;
        pick_flip[2]  = cfg_q.flip_b;
    end

    for (genvar p = 0; p < N_PICKS; p++) begin : g_pick
        tile_pick #(.N(N_SIDES), .SW(SIDE_SEL_W)) u_pick (
            .side_in (side_in),
            .code    (pick_code[p]),
            .flip    (pick_flip[p]),
            .y       (pick_val[p])
        );
    end

    tile_ulm u_ulm (
        .clk      (clk),
        .rst_n    (ff_rst_n),
        .sel      (pick_val[0]),
        .a        (pick_val[1]),
        .b        (pick_val[2]),
        .reg_mode (cfg_q.reg_mode),
        .f_comb   (f_comb),
        .ff_q     (ff_q),
        .res      (res)
    );

    for (genvar s = 0; s < N_SIDES; s++) begin : g_route
        tile_route #(.N(N_SIDES), .SW(SIDE_SEL_W), .SIDE(s)) u_route (
            .res     (res),
            .side_in (side_in),
            .code    (route_code[s]),
            .y       (side_out[s])
        );
    end

    // Map the side vector back onto the named ports.
    always_comb begin : out_map
        n_out = side_out[0];
        e_out = side_out[1];
        s_out = side_out[2];
        w_out = side_out[3];
    end
endmodule

// File: rtl/tile_chk.sv
`timescale 1ns/1ps
// tile_chk: temporal checks for logic_tile, attached with bind.
// Assumes that the bench holds both resets low from time zero.
module tile_chk
    import tile_pkg::*;
(
    input logic      clk,
    input logic      cfg_rst_n,
    input logic      ff_rst_n,
    input logic      cfg_en,
    input logic      cfg_in,
    input tile_cfg_t cfg_q,
    input logic      f_comb,
    input logic      ff_q,
    input logic      n_in,
    input logic      e_in,
    input logic      s_in,
    input logic      w_in,
    input logic      n_out,
    input logic      e_out,
    input logic      s_out,
    input logic      w_out
);
    // R1: an enabled clock shifts the serial bit into the bottom of the register.
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        cfg_en |=> (cfg_q[0] == $past(cfg_in)) &&
                   (cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0])));

    // R2: with the enable low, the configuration holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        !cfg_en |=> $stable(cfg_q));

    // R3: the configuration reset clears every bit.
    p_cfg_clear_r3: assert property (@(posedge clk)
        !cfg_rst_n |=> (cfg_q == '0));

    // R7: the flip-flop holds the previous cycle's function value.
    p_ff_latency_r7: assert property (@(posedge clk)
        ff_rst_n |=> (ff_q == $past(f_comb)));

    // R8: the user reset clears the flip-flop.
    p_ff_clear_r8: assert property (@(posedge clk)
        !ff_rst_n |=> (ff_q == 1'b0));

    // R8: the user reset does not alter the configuration.
    p_ff_rst_keeps_cfg_r8: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        (!ff_rst_n && !cfg_en) |=> $stable(cfg_q));

    // R6: north pass-through for each of its three clockwise codes.
    p_route_n_r6: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        (cfg_q.route_n == 2'b01 |-> n_out == e_in) and
        (cfg_q.route_n == 2'b10 |-> n_out == s_in) and
        (cfg_q.route_n == 2'b11 |-> n_out == w_in));

    // R6: west pass-through wraps around to north first.
    p_route_w_r6: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        (cfg_q.route_w == 2'b01 |-> w_out == n_in) and
        (cfg_q.route_w == 2'b10 |-> w_out == e_in) and
        (cfg_q.route_w == 2'b11 |-> w_out == s_in));

    // R7: code 0 on east shows the registered or the combinational result.
    p_east_result_r7: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        (cfg_q.route_e == 2'b00) |->
            (e_out == (cfg_q.reg_mode ? ff_q : f_comb)));

    // R6: code 0 on south drives the cell result.
    p_south_result_r6: assert property (@(posedge clk) disable iff (!cfg_rst_n)
        (cfg_q.route_s == 2'b00 && !cfg_q.reg_mode) |-> (s_out == f_comb));
endmodule

bind logic_tile tile_chk u_chk (
    .clk       (clk),
    .cfg_rst_n (cfg_rst_n),
    .ff_rst_n  (ff_rst_n),
    .cfg_en    (cfg_en),
    .cfg_in    (cfg_in),
    .cfg_q     (cfg_q),
    .f_comb    (f_comb),
    .ff_q      (ff_q),
    .n_in      (n_in),
    .e_in      (e_in),
    .s_in      (s_in),
    .w_in      (w_in),
    .n_out     (n_out),
    .e_out     (e_out),
    .s_out     (s_out),
    .w_out     (w_out)
);

// File: tb/sim_logic_tile.sv
`timescale 1ns/1ps
// sim_logic_tile: self-checking bench for logic_tile with a behavioural
// reference model that is compared against the outputs on every clock.
module sim_logic_tile;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       cfg_rst_n = 1'b0;
    logic       ff_rst_n  = 1'b0;
    logic       cfg_en    = 1'b0;
    logic       cfg_in    = 1'b0;
    logic [3:0] din       = 4'b0000;   // index 0..3 = N, E, S, W
    logic       cfg_out, n_out, e_out, s_out, w_out;

    int    total = 0;
    int    bad   = 0;
    bit    watch = 1'b0;
    bit    done  = 1'b0;
    string tag   = "R3";

    logic [16:0] m_cfg;
    logic        m_ff;

    logic_tile u0 (
        .clk       (clk),
        .cfg_rst_n (cfg_rst_n),
        .ff_rst_n  (ff_rst_n),
        .cfg_en    (cfg_en),
        .cfg_in    (cfg_in),
        .cfg_out   (cfg_out),
        .n_in      (din[0]),
        .e_in      (din[1]),
        .s_in      (din[2]),
        .w_in      (din[3]),
        .n_out     (n_out),
        .e_out     (e_out),
        .s_out     (s_out),
        .w_out     (w_out)
    );

    // Reference logic function from the requirement text.
    function automatic logic ref_f(input logic [16:0] c, input logic [3:0] d);
        logic sv, a, b;
        sv = d[c[6:5]];
        a  = d[c[4:3]] ^ c[8];
        b  = d[c[2:1]] ^ c[7];
        return sv ? b : a;
    endfunction

    // Expected outputs as the packed vector {cfg_out, W, S, E, N}.
    function automatic logic [4:0] ref_ports();
        logic [4:0] r;
        logic       res;
        res  = m_cfg[0] ? m_ff : ref_f(m_cfg, din);
        r[4] = m_cfg[16];
        for (int s = 0; s < 4; s++) begin
            int code;
            code = int'(m_cfg[16-2*s -: 2]);
            r[s] = (code == 0) ? res : din[(s + code) % 4];
        end
        return r;
    endfunction

    // Model state update on every clock edge.
    always @(posedge clk) begin
        if (!cfg_rst_n)  m_cfg <= '0;
        else if (cfg_en) m_cfg <= {m_cfg[15:0], cfg_in};
        if (!ff_rst_n)   m_ff <= 1'b0;
        else             m_ff <= ref_f(m_cfg, din);
    end

    task automatic chk(input string t, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", t, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (watch)
            chk(tag, {cfg_out, w_out, s_out, e_out, n_out}, ref_ports());
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [16:0] w);
        for (int i = 16; i >= 0; i--) begin
            cfg_en = 1'b1;
            cfg_in = w[i];
            tick();
        end
        cfg_en = 1'b0;
        cfg_in = 1'b0;
    endtask

    function automatic logic [16:0] mk(input logic [1:0] rn, re, rs, rw,
                                       input logic fa, fb,
                                       input logic [1:0] ps, pa, pb,
                                       input logic cs);
        return {rn, re, rs, rw, fa, fb, ps, pa, pb, cs};
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [4:0] pre;
        logic [4:0] fin;
        logic [16:0] w1;
        logic [16:0] w2;

        repeat (3) tick();
        cfg_rst_n = 1'b1;
        ff_rst_n  = 1'b1;
        din       = 4'b0001;
        @(negedge clk);
        // R3: a cleared configuration drives n_in on all sides.
        chk("R3", {cfg_out, w_out, s_out, e_out, n_out}, 5'b01111);
        watch = 1'b1;
        tick();

        // R4: AND, with select = N, first input = N, second input = E.
        tag = "R4";
        load(mk(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 1'b0));
        for (int v = 0; v < 4; v++) begin
            din = {2'b10, v[1], v[0]};
            @(negedge clk);
            chk("R4", {1'b0, n_out, e_out, s_out, w_out},
                {1'b0, {4{v[0] & v[1]}}});
            tick();
        end

        // R5: XOR, with select = N, first input = E, second input = inverted E.
        tag = "R5";
        load(mk(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 2'd1, 2'd1, 1'b0));
        for (int v = 0; v < 4; v++) begin
            din = {2'b01, v[1], v[0]};
            @(negedge clk);
            chk("R5", {1'b0, n_out, e_out, s_out, w_out},
                {1'b0, {4{v[0] ^ v[1]}}});
            tick();
        end

        // R6: pass-through on every side for each clockwise code.
        tag = "R6";
        for (int c = 1; c < 4; c++) begin
            load(mk(c[1:0], c[1:0], c[1:0], c[1:0], 1'b0, 1'b0,
                    2'd0, 2'd0, 2'd0, 1'b0));
            for (int v = 0; v < 16; v++) begin
                din = v[3:0];
                @(negedge clk);
                chk("R6", {1'b0, w_out, s_out, e_out, n_out},
                    {1'b0, din[(3 + c) % 4], din[(2 + c) % 4],
                     din[(1 + c) % 4], din[c % 4]});
                tick();
            end
        end

        // R7: registered AND has exactly one cycle of latency.
        tag = "R7";
        load(mk(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 1'b1));
        din = 4'b0000;
        tick();
        din = 4'b0011;
        @(negedge clk);
        chk("R7", {4'b0000, n_out}, 5'b00000);
        tick();
        @(negedge clk);
        chk("R7", {4'b0000, n_out}, 5'b00001);
        tick();
        din = 4'b0001;
        @(negedge clk);
        chk("R7", {4'b0000, s_out}, 5'b00001);
        tick();
        @(negedge clk);
        chk("R7", {4'b0000, s_out}, 5'b00000);
        tick();

        // R8: the user reset clears the flip-flop and keeps the configuration.
        tag = "R8";
        din = 4'b0011;
        tick();
        ff_rst_n = 1'b0;
        tick();
        ff_rst_n = 1'b1;
        @(negedge clk);
        chk("R8", {4'b0000, w_out}, 5'b00000);
        tick();
        @(negedge clk);
        chk("R8", {4'b0000, w_out}, 5'b00001);
        tick();

        // R2: toggling cfg_in with the enable low changes nothing.
        tag = "R2";
        @(negedge clk);
        pre = {cfg_out, w_out, s_out, e_out, n_out};
        tick();
        for (int i = 0; i < 20; i++) begin
            cfg_in = i[0];
            tick();
        end
        cfg_in = 1'b0;
        @(negedge clk);
        chk("R2", {cfg_out, w_out, s_out, e_out, n_out}, pre);
        tick();

        // R1: chain output replays the previous word MSB first.
        tag = "R1";
        w1 = 17'h1A5C3;
        w2 = 17'h0F00F;
        load(w1);
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk);
            chk("R1", {4'b0000, cfg_out}, {4'b0000, w1[i]});
            cfg_en = 1'b1;
            cfg_in = w2[i];
            tick();
        end
        cfg_en = 1'b0;
        @(negedge clk);
        chk("R1", {4'b0000, cfg_out}, {4'b0000, w2[16]});
        tick();

        // R3: a configuration clear returns all sides to n_in.
        tag = "R3";
        load(mk(2'd2, 2'd3, 2'd1, 2'd2, 1'b1, 1'b0, 2'd3, 2'd2, 2'd1, 1'b0));
        din = 4'b0001;
        cfg_rst_n = 1'b0;
        tick();
        cfg_rst_n = 1'b1;
        @(negedge clk);
        fin = {cfg_out, w_out, s_out, e_out, n_out};
        chk("R3", fin, 5'b01111);
        tick();
        din = 4'b1110;
        @(negedge clk);
        chk("R3", {cfg_out, w_out, s_out, e_out, n_out}, 5'b00000);
        tick();

        watch = 1'b0;
        report();
    end
endmodule